// File: doc/BRIEF.md
# Exception-Return Flag Stack Unit

This block owns the processor's 32-bit condition/status word. The lower 28 bits of that word hold a stack of flag groups, and each group is ten bits wide. The block also holds the kernel and user stack pointers.

Three operations act on the status word:
- **Return-from-exception** pops the flag stack. The two most significant bits are kept, bits [29:28] are cleared, and the rest of the stack moves down by ten places. The pending flag is then set unless the restart flag is present.
- **Set-flags** ORs a mask into the status word.
- **Clear-flags** removes the mask bits from the status word.

When an operation enters user mode, the unit saves the live stack pointer into its kernel register. It then drives the user stack pointer as the new stack pointer, together with a one-cycle mode-change pulse.

The surrounding core presents one operation per cycle, the current stack pointer and a mask. It writes back `sp_out` whenever `mode_chg` is high. Flag bit positions:

| Flag | Bit |
|---|---|
| C | 0 |
| V | 1 |
| Z | 2 |
| N | 3 |
| X | 4 |
| U (user mode) | 5 |
| P (pending) | 7 |
| R (restart) | 8 |

Top module: `flagstk_unit`

## Requirements
- R1: After reset `status`, `ksp`, `sp_out` and the internal user stack pointer are zero, and `mode_chg` is low.
- R2: One cycle after `op_ret`, the status bits change as follows (before the R3 rule is applied):
  - bits [31:30] keep their value;
  - bits [29:18] read zero;
  - bits [17:0] hold the old bits [27:10].
- R3: After a return, status bit 7 (P) is 1 when the shifted bit 8 (R) is 0. Otherwise it equals the shifted bit 7, which is the old bit 17.
- R4: When the old status bit 15 is 1, a return produces a stack swap. This bit becomes U (bit 5) after the shift. The swap does three things one cycle later:
  - `ksp` takes `sp_in`;
  - `sp_out` takes the user stack pointer;
  - `mode_chg` is high for that one cycle.
- R5: One cycle after `op_set`, `status` equals the old status OR `flag_mask`.
- R6: One cycle after `op_clr`, `status` equals the old status AND the inverse of `flag_mask`.
- R7: A set-flags performs the R4 stack swap only when two conditions hold: status bit 5 (U) was 0, and `flag_mask` bit 5 is 1. A set-flags in user mode never swaps.
- R8: When several operations are asserted together, return wins over set, and set wins over clear.
- R9: In a cycle with no operation, `status`, `ksp` and `sp_out` hold their values and `mode_chg` stays low.
- R10: `usp_we` loads `usp_wdata` into the user stack pointer. That value is what a later swap drives on `sp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_ret | input | 1 | Return-from-exception: pop the flag stack |
| op_set | input | 1 | OR `flag_mask` into status |
| op_clr | input | 1 | Clear the `flag_mask` bits in status |
| flag_mask | input | 32 | Mask for set/clear |
| sp_in | input | 32 | Live stack pointer from the register file |
| usp_we | input | 1 | Load the user stack pointer |
| usp_wdata | input | 32 | New user stack pointer value |
| status | output | 32 | Condition/status word |
| ksp | output | 32 | Saved kernel stack pointer |
| sp_out | output | 32 | Stack pointer to write back on a mode change |
| mode_chg | output | 1 | One-cycle pulse: a stack swap happened |

## Verification
The bound checker watches the following relations on every cycle:
- the bit movement of a pop, and the pending-flag rule;
- that a pop swaps exactly when the old bit 15 was set, and that the kernel pointer then captures `sp_in`;
- the OR and AND-NOT results of set and clear;
- the set-flags swap condition;
- that idle cycles change nothing.

The internal user pointer is not a port, so only the directed scenarios can show the following:
- that a written user pointer reaches `sp_out` on a swap;
- the outcome of colliding operations;
- that a second user-mode entry while already in user mode leaves `ksp` untouched.

// File: rtl/flagstk_pkg.sv
package flagstk_pkg;
    localparam int W         = 32;
    localparam int FLAG_U    = 5;
    localparam int FLAG_P    = 7;
    localparam int FLAG_R    = 8;
    localparam int POP_SHIFT = 10;
    localparam int KEEP_BITS = 2;
    localparam int GAP_BITS  = 2;

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] ksp;
        logic [W-1:0] usp;
        logic [W-1:0] sp;
        logic         chg;
    } unit_state_t;
endpackage

// File: rtl/flagstk_pop.sv
module flagstk_pop #(
    parameter int W     = 32,
    parameter int SHIFT = 10,
    parameter int KEEP  = 2,
    parameter int GAP   = 2,
    parameter int U_BIT = 5,
    parameter int P_BIT = 7,
    parameter int R_BIT = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         enter_user
);
    localparam int STACK_W = W - KEEP - GAP;
    localparam logic [W-1:0] KEEP_M  = {{KEEP{1'b1}}, {(W-KEEP){1'b0}}};
    localparam logic [W-1:0] STACK_M = {{(KEEP+GAP){1'b0}}, {STACK_W{1'b1}}};

    logic [W-1:0] shifted;

    always_comb begin
        shifted = (cur & KEEP_M) | ((cur & STACK_M) >> SHIFT);
        nxt     = shifted;
        if (!shifted[R_BIT]) begin
            nxt[P_BIT] = 1'b1;
        end
        enter_user = shifted[U_BIT];
    end
endmodule

// File: rtl/flagstk_mask.sv
module flagstk_mask #(
    parameter int W     = 32,
    parameter int U_BIT = 5
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    input  logic         do_set,
    output logic [W-1:0] nxt,
    output logic         enter_user
);
    always_comb begin
        nxt        = do_set ? (cur | mask) : (cur & ~mask);
        enter_user = do_set && !cur[U_BIT] && mask[U_BIT];
    end
endmodule

// File: rtl/flagstk_unit.sv
module flagstk_unit
    import flagstk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_ret,
    input  logic         op_set,
    input  logic         op_clr,
    input  logic [31:0]  flag_mask,
    input  logic [31:0]  sp_in,
    input  logic         usp_we,
    input  logic [31:0]  usp_wdata,
    output logic [31:0]  status,
    output logic [31:0]  ksp,
    output logic [31:0]  sp_out,
    output logic         mode_chg
);
    unit_state_t  st_d, st_q;
    logic [W-1:0] pop_nxt, msk_nxt;
    logic         pop_user, msk_user;

    flagstk_pop #(
        .W(W), .SHIFT(POP_SHIFT), .KEEP(KEEP_BITS), .GAP(GAP_BITS),
        .U_BIT(FLAG_U), .P_BIT(FLAG_P), .R_BIT(FLAG_R)
    ) u_pop (
        .cur        (st_q.status),
        .nxt        (pop_nxt),
        .enter_user (pop_user)
    );

    flagstk_mask #(.W(W), .U_BIT(FLAG_U)) u_mask (
        .cur        (st_q.status),
        .mask       (flag_mask),
        .do_set     (op_set),
        .nxt        (msk_nxt),
        .enter_user (msk_user)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (usp_we) begin
            st_d.usp = usp_wdata;
        end
        if (op_ret) begin
            st_d.status = pop_nxt;
            if (pop_user) begin
                st_d.ksp = sp_in;
                st_d.sp  = st_q.usp;
                st_d.chg = 1'b1;
            end
        end else if (op_set || op_clr) begin
            st_d.status = msk_nxt;
            if (msk_user) begin
                st_d.ksp = sp_in;
                st_d.sp  = st_q.usp;
                st_d.chg = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status   = st_q.status;
    assign ksp      = st_q.ksp;
    assign sp_out   = st_q.sp;
    assign mode_chg = st_q.chg;
endmodule

// File: rtl/flagstk_chk.sv
module flagstk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_ret,
    input logic        op_set,
    input logic        op_clr,
    input logic [31:0] flag_mask,
    input logic [31:0] sp_in,
    input logic [31:0] status,
    input logic [31:0] ksp,
    input logic [31:0] sp_out,
    input logic        mode_chg
);
    p_ret_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |=> (status[31:30] == $past(status[31:30])) && (status[29:18] == '0)
                   && (status[17:8] == $past(status[27:18])) && (status[6:0] == $past(status[16:10])));

    p_ret_pflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |=> status[7] == ($past(status[17]) || !$past(status[18])));

    p_ret_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |=> mode_chg == $past(status[15]));

    p_ret_ksp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ret && status[15]) |=> ksp == $past(sp_in));

    p_set_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_set && !op_ret) |=> ((status & $past(flag_mask)) == $past(flag_mask))
            && ((status & ~$past(flag_mask)) == ($past(status) & ~$past(flag_mask))));

    p_clr_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_clr && !op_ret && !op_set) |=> ((status & $past(flag_mask)) == '0)
            && ((status | $past(flag_mask)) == ($past(status) | $past(flag_mask))));

    p_set_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_set && !op_ret) |=> mode_chg == (!$past(status[5]) && $past(flag_mask[5])));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_ret || op_set || op_clr) |=> $stable(status) && $stable(ksp) && $stable(sp_out) && !mode_chg);
endmodule

bind flagstk_unit flagstk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_ret    (op_ret),
    .op_set    (op_set),
    .op_clr    (op_clr),
    .flag_mask (flag_mask),
    .sp_in     (sp_in),
    .status    (status),
    .ksp       (ksp),
    .sp_out    (sp_out),
    .mode_chg  (mode_chg)
);

// File: tb/sim_flagstk_unit.sv
module sim_flagstk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_ret = 1'b0, op_set = 1'b0, op_clr = 1'b0;
    logic [31:0] flag_mask = '0, sp_in = '0, usp_wdata = '0;
    logic        usp_we = 1'b0;
    logic [31:0] status, ksp, sp_out;
    logic        mode_chg;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_status = '0, m_ksp = '0, m_usp = '0, m_sp = '0;
    logic        m_chg = 1'b0;

    always #2 clk = ~clk;

    flagstk_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_ret(op_ret), .op_set(op_set), .op_clr(op_clr),
        .flag_mask(flag_mask), .sp_in(sp_in), .usp_we(usp_we), .usp_wdata(usp_wdata),
        .status(status), .ksp(ksp), .sp_out(sp_out), .mode_chg(mode_chg)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "status", status, m_status);
        chk(tag, "ksp", ksp, m_ksp);
        chk(tag, "sp_out", sp_out, m_sp);
        chk(tag, "mode_chg", {31'd0, mode_chg}, {31'd0, m_chg});
    endtask

    task automatic swap_model(input logic [31:0] sp);
        m_ksp = sp;
        m_sp  = m_usp;
        m_chg = 1'b1;
    endtask

    task automatic apply(input logic r, input logic s, input logic c,
                         input logic [31:0] m, input logic [31:0] sp, input string tag);
        logic [31:0] sh;
        @(negedge clk);
        op_ret = r; op_set = s; op_clr = c; flag_mask = m; sp_in = sp;
        @(posedge clk);
        m_chg = 1'b0;
        if (r) begin
            sh = (m_status & 32'hC000_0000) | ((m_status & 32'h0FFF_FFFF) >> 10);
            if (!sh[8]) sh[7] = 1'b1;
            if (sh[5]) swap_model(sp);
            m_status = sh;
        end else if (s) begin
            if (!m_status[5] && m[5]) swap_model(sp);
            m_status = m_status | m;
        end else if (c) begin
            m_status = m_status & ~m;
        end
        #1;
        chk_all(tag);
        op_ret = 1'b0; op_set = 1'b0; op_clr = 1'b0;
    endtask

    task automatic write_usp(input logic [31:0] v);
        @(negedge clk);
        usp_we = 1'b1; usp_wdata = v;
        @(posedge clk);
        m_usp = v;
        m_chg = 1'b0;
        #1;
        usp_we = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk_all("R1");
    endtask

    task automatic t_setclr;
        apply(0, 1, 0, 32'h0000_0013, 32'h0, "R5");
        apply(0, 1, 0, 32'hA5A0_0000, 32'h0, "R5");
        apply(0, 0, 1, 32'h0000_0011, 32'h0, "R6");
        apply(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R6");
    endtask

    task automatic t_set_swap;
        write_usp(32'h1000_0000);
        apply(0, 1, 0, 32'h0000_0020, 32'h0000_2222, "R7 R10");
        apply(0, 1, 0, 32'h0000_0021, 32'h0000_3333, "R7 user no swap");
        apply(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R6");
    endtask

    task automatic t_ret;
        write_usp(32'h0BAD_F00D);
        apply(0, 1, 0, 32'hC000_8000, 32'h0, "R5");
        apply(1, 0, 0, 32'h0, 32'h0000_4444, "R2 R3 R4");
        apply(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R6");
        apply(0, 1, 0, 32'h3004_0400, 32'h0, "R5");
        apply(1, 0, 0, 32'h0, 32'h0000_5555, "R2 R3 restart");
        apply(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R6");
        apply(0, 1, 0, 32'h0006_0000, 32'h0, "R5");
        apply(1, 0, 0, 32'h0, 32'h0, "R3 P kept");
        apply(1, 0, 0, 32'h0, 32'h0, "R2 R3 double pop");
    endtask

    task automatic t_prio;
        apply(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R6");
        apply(0, 1, 0, 32'h0003_0C00, 32'h0, "R5");
        apply(1, 1, 1, 32'h0000_000F, 32'h0, "R8 ret wins");
        apply(0, 1, 1, 32'h0000_0040, 32'h0, "R8 set wins");
    endtask

    task automatic t_idle;
        apply(0, 0, 0, 32'hFFFF_FFFF, 32'h7777_7777, "R9");
        apply(0, 0, 0, 32'h0000_0020, 32'h1234_5678, "R9");
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_setclr();
        t_set_swap();
        t_ret();
        t_prio();
        t_idle();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule